// File: doc/BRIEF.md
# Reset Source Status Capture

This block merges the reset requests of a small chip into one system reset and keeps a read-only record of what caused the most recent reset. It has six request sources:

- a power-on indication, which acts as the block's own asynchronous reset;
- a low-voltage flag, gated by a reset-enable control;
- a single-cycle watchdog expiry pulse;
- an active-low external reset pin;
- a clock-monitor fault, gated by a monitor enable;
- a flag that says a low-leakage power mode is active.

All level inputs pass through a two-stage synchronizer before any decision is made. A new reset event starts when a request appears while the system reset is idle. At that moment the status register is rewritten with only the causes present. Each source that drives the event sets its own bit. When the low-leakage flag is high at that moment, a wakeup bit is also set. Any number of bits can be set by one event.

The system reset stays high for as long as any gated request stays high. A low-voltage condition therefore keeps the chip in reset until the supply recovers. After the last request goes away, the reset is held for a further fixed stretch of cycles. Software reads the status bits after the reset ends to find out why the chip restarted.

Top module: `rst_cause_capture`

## Requirements
- R1: A request input change reaches `sys_rst` and `rst_status` at the third rising clock edge after it is applied: two synchronizer stages, then one register stage.
- R2: The low-voltage flag causes a reset only while `lvd_rst_en` is 1. Such a reset stays asserted for as long as the flag stays high, and sets status bit 4.
- R3: A one-cycle pulse on `wdog_expire` causes a reset and sets status bit 2.
- R4: A clock-monitor fault causes a reset only while `clkmon_en` is 1, and sets status bit 3. With `clkmon_en` at 0 the fault changes neither `sys_rst` nor `rst_status`.
- R5: A low level on `ext_rst_n` causes a reset and sets status bit 1.
- R6: Status bit 0 is set when a reset event starts while `lowleak_active` is 1. The pin bit and the wakeup bit can therefore be set together. `lowleak_active` alone causes no reset and leaves `rst_status` unchanged.
- R7: At the start of every reset event, `rst_status` is cleared and then loaded with exactly the bits of the causes present. Simultaneous causes set several bits.
- R8: A request that arrives while `sys_rst` is already asserted extends the reset but leaves `rst_status` unchanged.
- R9: `sys_rst` falls exactly 16 clock edges after the last cycle in which a synchronized request was high. For a released level input, this is the 18th rising edge after the release.
- R10: `por_n` low asynchronously forces `sys_rst` to 1 and `rst_status` to 6'b110000 (bit 5 power-on, bit 4 low-voltage). After `por_n` rises, `sys_rst` stays 1 for 15 rising edges and falls at the 16th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| lvd_flag | input | 1 | Supply below threshold |
| lvd_rst_en | input | 1 | Allows the low-voltage flag to reset |
| wdog_expire | input | 1 | Watchdog timeout pulse, at least one cycle |
| ext_rst_n | input | 1 | External reset pin, active low |
| clkmon_fault | input | 1 | Reference clock out of range |
| clkmon_en | input | 1 | Clock monitor enable |
| lowleak_active | input | 1 | Low-leakage power mode is active |
| sys_rst | output | 1 | System reset, active high |
| rst_status | output | 6 | Cause of the last reset: [5] power-on, [4] low-voltage, [3] clock monitor, [2] watchdog, [1] pin, [0] wakeup |

## Verification
Each stimulus is applied on a falling edge. Reset assertion and the new status are then due after the third rising edge, so the bench samples them on the following falling edge. One sample taken a cycle earlier confirms that nothing shows too soon.

Release timing is counted the same way. The fall of `sys_rst` is checked at the 17th falling edge after a release, where it must still be high, and at the 18th, where it must be low. The power-on release is checked at the 15th and 16th falling edges.

For the gated and ignored inputs, the bench looks at both `sys_rst` and `rst_status` at the cycle where a reset would have appeared, and again after the hold interval.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
   // status bit positions (software decodes these)
   localparam int unsigned ST_W    = 6;
   localparam int unsigned ST_WAKE = 0;
   localparam int unsigned ST_PIN  = 1;
   localparam int unsigned ST_WDOG = 2;
   localparam int unsigned ST_LOC  = 3;
   localparam int unsigned ST_LVD  = 4;
   localparam int unsigned ST_POR  = 5;

   // synchronized input vector layout
   localparam int unsigned IN_W     = 7;
   localparam int unsigned IX_LVD   = 0;
   localparam int unsigned IX_LVDEN = 1;
   localparam int unsigned IX_WDOG  = 2;
   localparam int unsigned IX_PIN   = 3;
   localparam int unsigned IX_LOC   = 4;
   localparam int unsigned IX_CME   = 5;
   localparam int unsigned IX_LL    = 6;

   typedef logic [ST_W-1:0] status_t;
   localparam status_t ST_AT_POR = status_t'((32'd1 << ST_POR) | (32'd1 << ST_LVD));
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rcc_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("rcc_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rcc_cause.sv
module rcc_cause
   import rcc_pkg::*;
(
   input  logic [IN_W-1:0] s,
   output logic            req,
   output status_t         cause
);
   logic lvd_req, loc_req, wd_req, pin_req;

   always_comb begin
      lvd_req = s[IX_LVD] & s[IX_LVDEN];
      loc_req = s[IX_LOC] & s[IX_CME];
      wd_req  = s[IX_WDOG];
      pin_req = s[IX_PIN];
      req     = lvd_req | loc_req | wd_req | pin_req;
      cause          = '0;
      cause[ST_LVD]  = lvd_req;
      cause[ST_LOC]  = loc_req;
      cause[ST_WDOG] = wd_req;
      cause[ST_PIN]  = pin_req;
      cause[ST_WAKE] = s[IX_LL] & req;
   end
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
   parameter int unsigned STRETCH = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic req,
   output logic busy
);
   localparam int unsigned CW   = $clog2(STRETCH + 1);
   localparam logic [CW-1:0] LOAD = CW'(STRETCH);

   generate
      if (STRETCH < 2) begin : g_bad_stretch
         $error("rcc_stretch: STRETCH must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)         cnt <= LOAD;
      else if (req)        cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   AST_TAIL_QUIET: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(busy) |-> (!$past(req) && !$past(req, 2))); // R9
endmodule

// File: rtl/rcc_status.sv
module rcc_status
   import rcc_pkg::*;
(
   input  logic    clk,
   input  logic    arst_n,
   input  logic    req,
   input  logic    busy,
   input  status_t cause,
   output status_t status
);
   logic start;
   assign start = req & ~busy;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)    status <= ST_AT_POR;
      else if (start) status <= cause;
   end

   AST_FROZEN_IN_RST: assert property (@(posedge clk) disable iff (!arst_n)
      busy |=> $stable(status)); // R8
endmodule

// File: rtl/rst_cause_capture.sv
module rst_cause_capture
   import rcc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STRETCH     = 16
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            lvd_flag,
   input  logic            lvd_rst_en,
   input  logic            wdog_expire,
   input  logic            ext_rst_n,
   input  logic            clkmon_fault,
   input  logic            clkmon_en,
   input  logic            lowleak_active,
   output logic            sys_rst,
   output logic [ST_W-1:0] rst_status
);
   logic [IN_W-1:0] raw_in, syn_in;
   logic            req, busy;
   status_t         cause, status;

   always_comb begin
      raw_in           = '0;
      raw_in[IX_LVD]   = lvd_flag;
      raw_in[IX_LVDEN] = lvd_rst_en;
      raw_in[IX_WDOG]  = wdog_expire;
      raw_in[IX_PIN]   = ~ext_rst_n;
      raw_in[IX_LOC]   = clkmon_fault;
      raw_in[IX_CME]   = clkmon_en;
      raw_in[IX_LL]    = lowleak_active;
   end

   rcc_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .arst_n(por_n), .d(raw_in), .q(syn_in));

   rcc_cause u_cause (.s(syn_in), .req(req), .cause(cause));

   rcc_stretch #(.STRETCH(STRETCH)) u_stretch (
      .clk(clk), .arst_n(por_n), .req(req), .busy(busy));

   rcc_status u_status (
      .clk(clk), .arst_n(por_n), .req(req), .busy(busy),
      .cause(cause), .status(status));

   assign sys_rst    = busy;
   assign rst_status = status;

   AST_LVD_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
      (syn_in[IX_LVD] && syn_in[IX_LVDEN]) |=> sys_rst); // R2

   AST_EVENT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sys_rst) |-> (|rst_status[ST_POR-1:ST_PIN])); // R7

   AST_MASKED_LOC_QUIET: assert property (@(posedge clk) disable iff (!por_n)
      (!busy && syn_in[IX_LOC] && !syn_in[IX_CME] && !syn_in[IX_WDOG]
       && !syn_in[IX_PIN] && !(syn_in[IX_LVD] && syn_in[IX_LVDEN])) |=> !sys_rst); // R4
endmodule

// File: tb/sim_rst_cause_capture.sv
module sim_rst_cause_capture;
   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic lvd_flag = 0, lvd_rst_en = 0, wdog_expire = 0, ext_rst_n = 1;
   logic clkmon_fault = 0, clkmon_en = 0, lowleak_active = 0;
   logic sys_rst;
   logic [5:0] rst_status;
   int n_tests = 0, n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rst_cause_capture u0 (
      .clk(clk), .por_n(por_n), .lvd_flag(lvd_flag), .lvd_rst_en(lvd_rst_en),
      .wdog_expire(wdog_expire), .ext_rst_n(ext_rst_n), .clkmon_fault(clkmon_fault),
      .clkmon_en(clkmon_en), .lowleak_active(lowleak_active),
      .sys_rst(sys_rst), .rst_status(rst_status));

   // stim bits: [6] lowleak [5] clkmon_en [4] fault [3] pin asserted [2] wdog [1] lvd_en [0] lvd
   // row: {stim[6:0], exp_rst, exp_status[5:0]}
   localparam logic [13:0] VEC [0:9] = '{
      {7'b0000100, 1'b1, 6'b000100},
      {7'b0000001, 1'b0, 6'b000100},
      {7'b0000011, 1'b1, 6'b010000},
      {7'b0010000, 1'b0, 6'b010000},
      {7'b0110000, 1'b1, 6'b001000},
      {7'b0001000, 1'b1, 6'b000010},
      {7'b1001000, 1'b1, 6'b000011},
      {7'b1000100, 1'b1, 6'b000101},
      {7'b0110100, 1'b1, 6'b001100},
      {7'b1000000, 1'b0, 6'b001100}
   };
   string TAG [0:9] = '{"R3", "R2", "R2", "R4", "R4", "R5", "R6", "R6", "R7", "R6"};

   task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic apply(input logic [6:0] s);
      lvd_flag = s[0]; lvd_rst_en = s[1]; wdog_expire = s[2]; ext_rst_n = ~s[3];
      clkmon_fault = s[4]; clkmon_en = s[5]; lowleak_active = s[6];
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      // R10: power-on state and release
      repeat (3) @(negedge clk);
      chk("R10 rst in por", {5'b0, sys_rst}, 6'd1);
      chk("R10 status in por", rst_status, 6'b110000);
      por_n = 1'b1;
      repeat (15) @(negedge clk);
      chk("R10 rst before edge 16", {5'b0, sys_rst}, 6'd1);
      @(negedge clk);
      chk("R10 rst released", {5'b0, sys_rst}, 6'd0);
      chk("R10 status after release", rst_status, 6'b110000);

      // table walk
      for (int i = 0; i < 10; i++) begin
         apply(VEC[i][13:7]);
         @(negedge clk);
         wdog_expire = 1'b0;
         repeat (2) @(negedge clk);
         chk({TAG[i], " R1 rst"}, {5'b0, sys_rst}, {5'b0, VEC[i][6]});
         chk({TAG[i], " status"}, rst_status, VEC[i][5:0]);
         repeat (4) @(negedge clk);
         chk({TAG[i], " rst hold"}, {5'b0, sys_rst}, {5'b0, VEC[i][6]});
         apply(7'b0);
         repeat (22) @(negedge clk);
         chk({TAG[i], " rst idle"}, {5'b0, sys_rst}, 6'd0);
         chk({TAG[i], " status kept"}, rst_status, VEC[i][5:0]);
      end

      // R1: watchdog latency, exact edge
      wdog_expire = 1'b1;
      @(negedge clk);
      wdog_expire = 1'b0;
      @(negedge clk);
      chk("R1 no early rst", {5'b0, sys_rst}, 6'd0);
      @(negedge clk);
      chk("R1 rst on third edge", {5'b0, sys_rst}, 6'd1);
      chk("R3 wdog bit", rst_status, 6'b000100);

      // R8: late cause during active reset
      repeat (2) @(negedge clk);
      lvd_flag = 1; lvd_rst_en = 1; lowleak_active = 1;
      repeat (4) @(negedge clk);
      chk("R8 status unchanged", rst_status, 6'b000100);
      chk("R8 rst extended", {5'b0, sys_rst}, 6'd1);
      repeat (30) @(negedge clk);
      chk("R2 lvd held", {5'b0, sys_rst}, 6'd1);
      apply(7'b0);
      repeat (22) @(negedge clk);
      chk("R8 rst ends", {5'b0, sys_rst}, 6'd0);
      chk("R8 status after", rst_status, 6'b000100);

      // R9: exact stretch after pin release
      ext_rst_n = 1'b0;
      repeat (6) @(negedge clk);
      ext_rst_n = 1'b1;
      repeat (17) @(negedge clk);
      chk("R9 rst at edge 17", {5'b0, sys_rst}, 6'd1);
      @(negedge clk);
      chk("R9 rst off at edge 18", {5'b0, sys_rst}, 6'd0);
      chk("R5 pin bit", rst_status, 6'b000010);

      // R10: asynchronous power-on mid-run
      @(negedge clk);
      #3 por_n = 1'b0;
      #2;
      chk("R10 async rst", {5'b0, sys_rst}, 6'd1);
      chk("R10 async status", rst_status, 6'b110000);
      @(negedge clk);
      por_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R10 released again", {5'b0, sys_rst}, 6'd0);

      finish_run();
   end
endmodule